// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block multiplies two unsigned operands of `N` bits each and returns the full `2N`-bit product with no clock and no state. An array of AND gates forms every partial-product bit. The bit built from operand bit `i` and multiplier bit `j` lands at weight `i+j`. Partial-product row `j` is therefore operand A masked by multiplier bit `j` and shifted left by `j`.

Rows 0 and 1 form the first carry-save pair. Each later row is merged into the pair by one carry-save stage. In a stage, every column with three live bits uses a full adder and every column with two live bits uses a half adder. A column with one live bit passes it straight through, and an empty column costs nothing. Which columns are live is worked out at elaboration time from `N`.

Within a stage the columns do not depend on each other, so a stage is a single adder deep. When only two numbers remain, one ripple carry-propagate adder sums them into the product. A designer uses the block as a drop-in combinational multiplier and adds registers around it as the timing budget requires. `N` must be at least 2.

Top module: `csm_mult`

## Requirements
- R1: For every pair of unsigned operands, `prod` equals `op_a * op_b` over the full `2N` bits.
- R2: With `N = 4`, operands 12 and 13 give the product 156 (binary 10011100).
- R3: Each carry-save stage keeps the arithmetic total: its sum word plus its carry word equals the sum of its three input words. A carry formed in column k enters column k+1 of the next word, and no carry leaves the top column.
- R4: Exactly two words reach the carry-propagate adder, and its result equals their arithmetic sum with no carry beyond bit `2N-1`.
- R5: Product bit 0 equals `op_a[0] AND op_b[0]` and involves no adder.
- R6: The largest operands, all ones, give `(2^N-1)^2`; with `N = 4`, 15 × 15 gives 225.
- R7: When either operand is zero, the product is zero.
- R8: When one operand is 1, the product equals the other operand, zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | Unsigned multiplicand |
| op_b | input | N | Unsigned multiplier |
| prod | output | 2N | Unsigned product |

## Verification
The default `N = 4` is swept over all 256 operand pairs against an arithmetic product. This sweep separates a misplaced partial-product weight, a wrong full- or half-adder choice, or a carry sent to the wrong column from a correct array, since each of these breaks some pair. Zero and unit operands show whether a row leaks into columns it should not touch. The all-ones pair drives carries through every column into the top product bit. The 12 × 13 case and the bit-0 checks pin the stated product value and the direct path to the least significant bit.

// File: rtl/csm_pkg.sv
package csm_pkg;

  localparam int MASK_W = 256;

  // Columns in which partial-product row j can carry a nonzero bit.
  function automatic logic [MASK_W-1:0] row_mask(int n, int j);
    logic [MASK_W-1:0] m;
    m = ((MASK_W'(1) << n) - MASK_W'(1)) << j;
    return m;
  endfunction

  // Live-column mask of the sum word (want_carry = 0) or the carry word
  // (want_carry = 1) after rows 0..t have been merged; t >= 1.
  function automatic logic [MASK_W-1:0] word_mask(int n, int t, bit want_carry);
    logic [MASK_W-1:0] ms, mc, mp, nms, nmc;
    int cnt;
    ms = row_mask(n, 0);
    mc = row_mask(n, 1);
    for (int u = 2; u <= t; u++) begin
      mp  = row_mask(n, u);
      nms = '0;
      nmc = '0;
      for (int k = 0; k < 2 * n; k++) begin
        cnt = int'(ms[k]) + int'(mc[k]) + int'(mp[k]);
        if (cnt > 0) nms[k] = 1'b1;
        if (cnt >= 2 && k < 2 * n - 1) nmc[k+1] = 1'b1;
      end
      ms = nms;
      mc = nmc;
    end
    return want_carry ? mc : ms;
  endfunction

endpackage

// File: rtl/csm_pp_array.sv
module csm_pp_array #(
  parameter int N = 4,
  localparam int W = 2 * N
) (
  input  logic [N-1:0]        a,
  input  logic [N-1:0]        b,
  output logic [N-1:0][W-1:0] rows
);

  for (genvar j = 0; j < N; j++) begin : g_row
    for (genvar k = 0; k < W; k++) begin : g_col
      if (k >= j && k < j + N) begin : g_and
        assign rows[j][k] = a[k-j] & b[j];
      end else begin : g_zero
        assign rows[j][k] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/csm_cell.sv
module csm_cell #(
  parameter logic [2:0] LIVE = 3'b111
) (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic c
);

  localparam int NLIVE = int'(LIVE[0]) + int'(LIVE[1]) + int'(LIVE[2]);

  if (NLIVE == 3) begin : g_full
    assign s = x ^ y ^ z;
    assign c = (x & y) | (x & z) | (y & z);
  end else if (NLIVE == 2) begin : g_half
    logic p, q;
    assign p = LIVE[0] ? x : y;
    assign q = LIVE[2] ? z : y;
    assign s = p ^ q;
    assign c = p & q;
  end else if (NLIVE == 1) begin : g_pass
    assign s = LIVE[0] ? x : (LIVE[1] ? y : z);
    assign c = 1'b0;
  end else begin : g_empty
    assign s = 1'b0;
    assign c = 1'b0;
  end

  always_comb begin
    AST_DEAD_INPUT_ZERO: assert (((x & ~LIVE[0]) | (y & ~LIVE[1]) | (z & ~LIVE[2])) == 1'b0); // R3
    AST_CELL_COUNT: assert ({1'b0, s} + {c, 1'b0} ==
                            {1'b0, x & LIVE[0]} + {1'b0, y & LIVE[1]} + {1'b0, z & LIVE[2]}); // R3
  end

endmodule

// File: rtl/csm_csa_stage.sv
module csm_csa_stage #(
  parameter int N = 4,
  parameter int STAGE = 2,
  localparam int W = 2 * N
) (
  input  logic [W-1:0] s_in,
  input  logic [W-1:0] c_in,
  input  logic [W-1:0] p_in,
  output logic [W-1:0] s_out,
  output logic [W-1:0] c_out
);
  import csm_pkg::*;

  localparam logic [MASK_W-1:0] MS = word_mask(N, STAGE - 1, 1'b0);
  localparam logic [MASK_W-1:0] MC = word_mask(N, STAGE - 1, 1'b1);
  localparam logic [MASK_W-1:0] MP = row_mask(N, STAGE);

  logic [W-1:0] cy;

  for (genvar k = 0; k < W; k++) begin : g_col
    csm_cell #(.LIVE({MP[k], MC[k], MS[k]})) u_cell (
      .x(s_in[k]), .y(c_in[k]), .z(p_in[k]), .s(s_out[k]), .c(cy[k])
    );
  end

  assign c_out = {cy[W-2:0], 1'b0};

  always_comb begin
    AST_TOP_CARRY_ZERO: assert (cy[W-1] == 1'b0); // R3
    AST_STAGE_TOTAL: assert ((W+2)'(s_out) + (W+2)'(c_out) ==
                             (W+2)'(s_in) + (W+2)'(c_in) + (W+2)'(p_in)); // R3
  end

endmodule

// File: rtl/csm_cpa.sv
module csm_cpa #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum
);

  logic [W:0] rc;
  assign rc[0] = 1'b0;

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign sum[k]  = x[k] ^ y[k] ^ rc[k];
    assign rc[k+1] = (x[k] & y[k]) | (rc[k] & (x[k] ^ y[k]));
  end

  always_comb begin
    AST_CPA_SUM: assert ({rc[W], sum} == {1'b0, x} + {1'b0, y}); // R4
    AST_CPA_NO_OVERFLOW: assert (rc[W] == 1'b0); // R4
  end

endmodule

// File: rtl/csm_mult.sv
module csm_mult #(
  parameter int N = 4,
  localparam int W = 2 * N
) (
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  output logic [W-1:0] prod
);

  logic [N-1:0][W-1:0] rows;
  logic [N-1:1][W-1:0] sw;
  logic [N-1:1][W-1:0] cw;

  csm_pp_array #(.N(N)) u_pp (.a(op_a), .b(op_b), .rows(rows));

  assign sw[1] = rows[0];
  assign cw[1] = rows[1];

  for (genvar t = 2; t < N; t++) begin : g_stage
    csm_csa_stage #(.N(N), .STAGE(t)) u_stage (
      .s_in(sw[t-1]), .c_in(cw[t-1]), .p_in(rows[t]),
      .s_out(sw[t]), .c_out(cw[t])
    );
  end

  csm_cpa #(.W(W)) u_cpa (.x(sw[N-1]), .y(cw[N-1]), .sum(prod));

  always_comb begin
    AST_PRODUCT_EXACT: assert (prod == W'(op_a) * W'(op_b)); // R1
    AST_BIT0_DIRECT: assert (prod[0] == (op_a[0] & op_b[0])); // R5
    AST_ZERO_OPERAND: assert (!((op_a == '0) || (op_b == '0)) || prod == '0); // R7
  end

endmodule

// File: tb/csm_mult_test.sv
module csm_mult_test;

  localparam int N = 4;
  localparam int W = 2 * N;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [N-1:0] op_a, op_b;
  logic [W-1:0] prod;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  csm_mult #(.N(N)) uut (.op_a(op_a), .op_b(op_b), .prod(prod));

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, op_a, op_b, got, exp);
    end
  endtask

  task automatic apply(input int a, input int b);
    @(posedge clk);
    op_a = N'(a);
    op_b = N'(b);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    op_a = '0;
    op_b = '0;
    @(negedge clk);
    check("R7 idle zero operands", prod, '0);

    apply(12, 13);
    check("R2 twelve times thirteen", prod, W'(156));

    apply(15, 15);
    check("R6 all ones", prod, W'(225));
    check("R6 top bit", W'(prod[W-1]), W'(1));

    for (int v = 0; v < (1 << N); v++) begin
      apply(v, 0);
      check("R7 b zero", prod, '0);
      apply(0, v);
      check("R7 a zero", prod, '0);
      apply(v, 1);
      check("R8 b one", prod, W'(v));
      apply(1, v);
      check("R8 a one", prod, W'(v));
    end

    for (int a = 0; a < (1 << N); a++) begin
      for (int b = 0; b < (1 << N); b++) begin
        apply(a, b);
        check("R1 R3 R4 sweep product", prod, W'(a * b));
        check("R5 bit0", W'(prod[0]), W'((a & b) & 1));
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule